// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable, reduced-depth model of a synchronous static RAM in which the data phase of every access comes exactly one clock after its address and control phase. Reads and writes keep the same one-cycle offset, so a read can follow a write, or a write a read, with no idle bus cycle. Read data is flow-through: the array word reaches the output port through logic only, with no output register. The data bus is split into an input word, an output word and an output-drive flag. This lets a chip-level bus model or a tri-state pad ring combine them.

A host loads a new access by driving the advance control low while the chip is selected. It can then step a 2-bit burst counter by driving advance high. The counter steps through the four words of an aligned group, in either linear or interleaved order. An active-low clock enable makes the model ignore an edge completely. Three chip-select inputs of mixed polarity qualify loads. Each of the four 9-bit lanes of the 36-bit word has its own active-low write strobe. An asynchronous output enable gates the bus drive.

Top module: `zbt_sram`

## Requirements
- R1: On an edge with `clk_en_n` low, `advance` low and the chip selected, the model captures `addr` and the access type (`rw_n` 1 = read, 0 = write). In the following cycle, a read drives `dout` from the array word at that address with `dout_en` high, and a write takes `din`.
- R2: The chip is selected only when `en1_n`=0, `en2_n`=0 and `en3`=1. A load edge with any of them false starts a deselect: it stops any burst, and `dout_en` is low in the next cycle.
- R3: A transfer whose data phase is under way completes on the next enabled edge, even when that edge carries a new load or a deselect. A write data phase ended by a deselect still stores its data.
- R4: An edge with `clk_en_n` high is ignored. The pipeline state, `dout`, `dout_en` and the array all stay unchanged, and a pending write is not stored until an enabled edge follows.
- R5: On an enabled edge with `advance` high, `addr`, `rw_n` and a pending access's type are not resampled. The burst counter steps by one, and the access type stays as it was loaded.
- R6: Burst addresses keep all bits above bit 1 of the loaded address. Bits [1:0] for step k (k = 0..3, mod 4) are (start + k) mod 4 when `burst_interleave`=0, and start XOR k when `burst_interleave`=1. After four steps the sequence returns to the start.
- R7: Lane n consists of `din[8n+7:8n]` plus parity bit `din[32+n]`, and the same positions in `dout`. Its strobe `lane_wr_n[n]` (active low) is sampled on the load edge and on every burst-advance edge. It controls whether lane n of the data presented in the next cycle is written. Strobes have no effect on reads.
- R8: `out_en_n` high forces `dout_en` low at once, whatever the pipeline state. During a write data phase `dout_en` is always low.
- R9: An advance edge that follows a deselect is a no-operation: `dout_en` stays low and nothing is written.
- R10: A read loaded on the edge that completes a write to the same address returns the newly written word.
- R11: After reset the pipeline holds a deselect state and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline state |
| clk_en_n | input | 1 | Active-low clock enable; high ignores the edge |
| addr | input | 8 | Word address, sampled on load edges |
| rw_n | input | 1 | Access type on load: 1 read, 0 write |
| advance | input | 1 | 0 loads a new access, 1 steps the burst |
| en1_n | input | 1 | Chip select, active low |
| en2_n | input | 1 | Chip select, active low |
| en3 | input | 1 | Chip select, active high |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| burst_interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | 36 | Write data for the current data phase |
| dout | output | 36 | Flow-through read data |
| dout_en | output | 1 | High when the model drives the bus |

## Verification
The bench writes every word, then reads every start address back as a five-beat burst in both orders. A wrong counter, order or wrap shows up as a mismatched word. The advance beats carry a write type and strobes that must be ignored, so a model that resampled the type would corrupt later reads. Directed cases cover the hazards. A read issued on the edge that stores a write must see the new data. All sixteen strobe patterns are tried, and a lane written from the wrong bits gives a wrong merge. All eight chip-select combinations are tried, and so are a no-operation after a deselect, a write data phase held across ignored edges, and an asynchronous output-enable drop. Each of these catches a model that drives the bus when it should float, or stores data on the wrong edge.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   // State of the access whose data phase is the current cycle
   typedef struct packed {
      logic       valid;
      logic       write;
      logic [1:0] step;
   } xfer_t;

   localparam xfer_t XFER_IDLE = '{valid: 1'b0, write: 1'b0, step: 2'd0};

   // Low two address bits of burst beat 'step' from start offset 'start'
   function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input logic       interleave);
      return interleave ? (start ^ step) : 2'(start + step);
   endfunction

endpackage

// File: rtl/zbt_pipe_ctrl.sv
module zbt_pipe_ctrl
   import zbt_pkg::*;
#(
   parameter int AW    = 8,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             advance,
   input  logic             rw_n,
   input  logic             sel,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] lane_wr_n,
   output logic             xfer_valid,
   output logic             xfer_write,
   output logic [1:0]       xfer_step,
   output logic [AW-1:0]    xfer_base,
   output logic [LANES-1:0] xfer_lanes,
   output logic             commit
);

   xfer_t            st_q;
   logic [AW-1:0]    base_q;
   logic [LANES-1:0] lanes_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= XFER_IDLE;
         base_q  <= '0;
         lanes_q <= '0;
      end else if (clk_en) begin
         if (!advance) begin
            if (sel) begin
               st_q.valid <= 1'b1;
               st_q.write <= ~rw_n;
               st_q.step  <= 2'd0;
               base_q     <= addr;
            end else begin
               st_q       <= XFER_IDLE;
            end
         end else begin
            st_q.step <= 2'(st_q.step + 2'd1);
         end
         lanes_q <= ~lane_wr_n;
      end
   end

   assign xfer_valid = st_q.valid;
   assign xfer_write = st_q.write;
   assign xfer_step  = st_q.step;
   assign xfer_base  = base_q;
   assign xfer_lanes = lanes_q;
   // A write data phase is stored on the next enabled edge, whatever it carries
   assign commit     = clk_en & st_q.valid & st_q.write;

   assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !advance && sel) |=>
         (st_q.valid && base_q == $past(addr) && st_q.step == 2'd0 &&
          st_q.write == !$past(rw_n)));

   assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !advance && !sel) |=> !st_q.valid);

   assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(st_q) && $stable(base_q) && $stable(lanes_q)));

   assert_advance_keeps_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && advance) |=>
         (st_q.write == $past(st_q.write) && st_q.valid == $past(st_q.valid) &&
          st_q.step == 2'($past(st_q.step) + 2'd1) && base_q == $past(base_q)));

endmodule

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr
   import zbt_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic [AW-1:0] base,
   input  logic [1:0]    step,
   input  logic          interleave,
   output logic [AW-1:0] beat_addr
);

   logic [1:0] low;

   assign low = beat_offset(base[1:0], step, interleave);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("zbt_burst_addr: AW must be at least 2");
      end else if (AW == 2) begin : g_group_only
         assign beat_addr = low;
      end else begin : g_with_upper
         assign beat_addr = {base[AW-1:2], low};
      end
   endgenerate

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
   parameter int DEPTH     = 256,
   parameter int AW        = 8,
   parameter int LANES     = 4,
   parameter int LANE_BITS = 9
) (
   input  logic                       clk,
   input  logic                       commit,
   input  logic [AW-1:0]              addr,
   input  logic [LANES-1:0]           lane_we,
   input  logic [LANES*LANE_BITS-1:0] wdata,
   output logic [LANES*LANE_BITS-1:0] rdata
);

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("zbt_lane_array: DEPTH must equal 2**AW");
      end
      for (genvar n = 0; n < LANES; n++) begin : g_lane
         logic [LANE_BITS-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (commit && lane_we[n]) begin
               mem[addr] <= wdata[n*LANE_BITS +: LANE_BITS];
            end
         end

         assign rdata[n*LANE_BITS +: LANE_BITS] = mem[addr];
      end
   endgenerate

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int LB    = BYTE_W + 1,
   localparam int DW    = LANES * LB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic [AW-1:0]    addr,
   input  logic             rw_n,
   input  logic             advance,
   input  logic             en1_n,
   input  logic             en2_n,
   input  logic             en3,
   input  logic [LANES-1:0] lane_wr_n,
   input  logic             out_en_n,
   input  logic             burst_interleave,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout,
   output logic             dout_en
);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("zbt_sram: DEPTH must be a power of two of at least 4");
      end
      if (LANES < 1 || BYTE_W < 1) begin : g_bad_lanes
         $error("zbt_sram: LANES and BYTE_W must be positive");
      end
   endgenerate

   logic             sel;
   logic             xfer_valid;
   logic             xfer_write;
   logic [1:0]       xfer_step;
   logic [AW-1:0]    xfer_base;
   logic [LANES-1:0] xfer_lanes;
   logic             commit;
   logic [AW-1:0]    beat_addr;
   logic [DW-1:0]    wpack;
   logic [DW-1:0]    rpack;

   assign sel = ~en1_n & ~en2_n & en3;

   zbt_pipe_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en     (~clk_en_n),
      .advance    (advance),
      .rw_n       (rw_n),
      .sel        (sel),
      .addr       (addr),
      .lane_wr_n  (lane_wr_n),
      .xfer_valid (xfer_valid),
      .xfer_write (xfer_write),
      .xfer_step  (xfer_step),
      .xfer_base  (xfer_base),
      .xfer_lanes (xfer_lanes),
      .commit     (commit)
   );

   zbt_burst_addr #(.AW(AW)) u_burst (
      .base       (xfer_base),
      .step       (xfer_step),
      .interleave (burst_interleave),
      .beat_addr  (beat_addr)
   );

   // Bus layout: data bytes low, one parity bit per lane above them
   generate
      for (genvar n = 0; n < LANES; n++) begin : g_pack
         assign wpack[n*LB +: LB]          = {din[LANES*BYTE_W + n], din[n*BYTE_W +: BYTE_W]};
         assign dout[n*BYTE_W +: BYTE_W]   = rpack[n*LB +: BYTE_W];
         assign dout[LANES*BYTE_W + n]     = rpack[n*LB + BYTE_W];
      end
   endgenerate

   zbt_lane_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_BITS(LB)) u_array (
      .clk     (clk),
      .commit  (commit),
      .addr    (beat_addr),
      .lane_we (xfer_lanes),
      .wdata   (wpack),
      .rdata   (rpack)
   );

   assign dout_en = xfer_valid & ~xfer_write & ~out_en_n;

   assert_write_phase_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !advance && sel && !rw_n) |=> !dout_en);

   assert_noop_after_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !advance && !sel) ##1 (!clk_en_n && advance) |=> !dout_en);

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;

   localparam logic [2:0] SEL   = 3'b001;  // {en1_n, en2_n, en3}
   localparam logic [2:0] DESEL = 3'b101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        rw_n = 1'b1;
   logic        advance = 1'b0;
   logic        en1_n = 1'b1, en2_n = 1'b1, en3 = 1'b0;
   logic [3:0]  lane_wr_n = 4'hF;
   logic        out_en_n = 1'b0;
   logic        burst_interleave = 1'b0;
   logic [35:0] din = '0;
   logic [35:0] dout;
   logic        dout_en;

   int n_checks = 0;
   int n_errors = 0;
   logic [35:0] exp_mem [256];

   always #2 clk = ~clk;

   zbt_sram u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .addr(addr), .rw_n(rw_n),
      .advance(advance), .en1_n(en1_n), .en2_n(en2_n), .en3(en3),
      .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .burst_interleave(burst_interleave),
      .din(din), .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [35:0] pat(input int a);
      return 36'(a) * 36'h1_0203_0405 ^ 36'hA_5A5A_C3C3;
   endfunction

   function automatic logic [35:0] merge(input logic [35:0] old_w, input logic [35:0] new_w,
                                         input logic [3:0] wr_n);
      logic [35:0] r = old_w;
      for (int n = 0; n < 4; n++) begin
         if (!wr_n[n]) begin
            r[n*8 +: 8] = new_w[n*8 +: 8];
            r[32+n]     = new_w[32+n];
         end
      end
      return r;
   endfunction

   task automatic chk_word(input string req, input logic [35:0] got, input logic [35:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic chk_bit(input string req, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: dout_en got %b expected %b", req, got, exp);
      end
   endtask

   // Present inputs for one edge, then step to just after that edge
   task automatic drv(input logic adv, input logic rw, input logic [7:0] a,
                      input logic [2:0] en, input logic [3:0] bw, input logic [35:0] d);
      advance = adv; rw_n = rw; addr = a;
      {en1_n, en2_n, en3} = en;
      lane_wr_n = bw; din = d;
      @(posedge clk); #1;
   endtask

   task automatic finish_up;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

   initial begin
      logic [7:0]  ba;
      logic [35:0] w;
      repeat (3) @(posedge clk);
      #1;
      chk_bit("R11 reset idle", dout_en, 1'b0);
      rst_n = 1'b1;
      drv(1, 1, 0, SEL, 4'hF, 0);
      chk_bit("R11 advance after reset is no-op", dout_en, 1'b0);

      // Fill every word with back-to-back writes; data trails control by one cycle
      drv(0, 0, 0, SEL, 4'h0, '0);
      for (int a = 1; a < 256; a++) begin
         drv(0, 0, 8'(a), SEL, 4'h0, pat(a - 1));
         if (a % 64 == 0) chk_bit("R8 write phase not driven", dout_en, 1'b0);
      end
      drv(0, 1, 0, DESEL, 4'h0, pat(255));   // R3: deselect completes last write
      chk_bit("R2 deselect floats bus", dout_en, 1'b0);
      for (int a = 0; a < 256; a++) exp_mem[a] = pat(a);

      // Five-beat read bursts from every start, both orders (R1, R5, R6)
      for (int m = 0; m < 2; m++) begin
         burst_interleave = m[0];
         for (int b = 0; b < 256; b++) begin
            drv(0, 1, 8'(b), SEL, 4'hF, '0);
            chk_bit("R1 read drives bus", dout_en, 1'b1);
            chk_word("R1 load read data", dout, exp_mem[b]);
            for (int k = 1; k <= 4; k++) begin
               // garbage address, write type and strobes must all be ignored (R5)
               drv(1, 0, ~8'(b), SEL, 4'h0, 36'hF_FFFF_FFFF);
               ba = 8'(b);
               ba[1:0] = m[0] ? (ba[1:0] ^ 2'(k)) : 2'(ba[1:0] + 2'(k));
               chk_word(m[0] ? "R6 interleaved beat" : "R6 linear beat", dout, exp_mem[ba]);
            end
         end
      end
      drv(0, 1, 0, DESEL, 4'hF, '0);
      burst_interleave = 1'b0;

      // R10: read loaded on the edge that stores a write to the same word
      drv(0, 0, 8'd5, SEL, 4'h0, '0);
      drv(0, 1, 8'd5, SEL, 4'hF, 36'h1_2345_6789);
      exp_mem[5] = 36'h1_2345_6789;
      chk_word("R10 read after write", dout, exp_mem[5]);
      drv(0, 1, 0, DESEL, 4'h0, 36'h0_DEAD_BEEF);

      // R7: all sixteen strobe patterns
      for (int s = 0; s < 16; s++) begin
         w = ~pat(s + 40);
         drv(0, 0, 8'(40 + s), SEL, 4'(s), '0);
         drv(0, 1, 8'(40 + s), SEL, 4'h0, w);     // strobes low on a read: no effect
         exp_mem[40 + s] = merge(exp_mem[40 + s], w, 4'(s));
         drv(0, 1, 8'(40 + s), SEL, 4'h0, 36'h5_5555_5555);
         chk_word("R7 lane merge", dout, exp_mem[40 + s]);
      end
      drv(0, 1, 0, DESEL, 4'hF, '0);

      // R5/R7: linear burst write from offset 2 with per-beat strobes
      drv(0, 0, 8'h62, SEL, 4'h0, '0);
      drv(1, 1, 8'h00, SEL, 4'b1110, 36'h0_1111_1111);
      chk_bit("R8 burst write phase not driven", dout_en, 1'b0);
      drv(1, 1, 8'h00, SEL, 4'h0, 36'h0_2222_2222);
      drv(1, 1, 8'h00, SEL, 4'b0111, 36'h0_3333_3333);
      drv(0, 1, 8'h62, SEL, 4'hF, 36'hF_4444_4444);
      exp_mem[8'h62] = 36'h0_1111_1111;
      exp_mem[8'h63] = merge(exp_mem[8'h63], 36'h0_2222_2222, 4'b1110);
      exp_mem[8'h60] = 36'h0_3333_3333;
      exp_mem[8'h61] = merge(exp_mem[8'h61], 36'hF_4444_4444, 4'b0111);
      chk_word("R5 burst write beat 0", dout, exp_mem[8'h62]);
      drv(1, 1, 8'h00, SEL, 4'hF, '0);
      chk_word("R5 burst write beat 1", dout, exp_mem[8'h63]);
      drv(1, 1, 8'h00, SEL, 4'hF, '0);
      chk_word("R6 burst write beat 2 wraps", dout, exp_mem[8'h60]);
      drv(1, 1, 8'h00, SEL, 4'hF, '0);
      chk_word("R7 burst write beat 3 lane strobe", dout, exp_mem[8'h61]);

      // R2: every select combination
      for (int e = 0; e < 8; e++) begin
         drv(0, 1, 8'h30, 3'(e), 4'hF, '0);
         chk_bit("R2 select decode", dout_en, (e == 1));
         if (e == 1) chk_word("R2 selected read", dout, exp_mem[8'h30]);
      end

      // R2/R9: deselect stops a burst, later advances are no-ops
      drv(0, 1, 8'h44, SEL, 4'hF, '0);
      drv(1, 1, 8'h00, SEL, 4'hF, '0);
      chk_word("R6 second beat before stop", dout, exp_mem[8'h45]);
      drv(0, 0, 8'h44, DESEL, 4'h0, '0);
      chk_bit("R2 burst stopped", dout_en, 1'b0);
      drv(1, 0, 8'h44, SEL, 4'h0, 36'h0_BAD0_BAD0);
      chk_bit("R9 no-op after deselect", dout_en, 1'b0);
      drv(1, 0, 8'h44, SEL, 4'h0, 36'h0_BAD0_BAD0);
      chk_bit("R9 second no-op", dout_en, 1'b0);
      drv(0, 1, 8'h44, SEL, 4'hF, 36'h0_BAD0_BAD0);
      for (int k = 0; k < 4; k++) begin
         if (k > 0) drv(1, 1, 8'h00, SEL, 4'hF, '0);
         chk_word("R9 nothing written by no-op", dout, exp_mem[8'h44 + k]);
      end

      // R4: ignored edges hold a read and a pending write
      drv(0, 1, 8'h70, SEL, 4'hF, '0);
      clk_en_n = 1'b1;
      drv(0, 1, 8'h71, SEL, 4'hF, '0);
      chk_word("R4 frozen read data", dout, exp_mem[8'h70]);
      chk_bit("R4 frozen read drive", dout_en, 1'b1);
      drv(0, 0, 8'h72, DESEL, 4'h0, '0);
      chk_word("R4 second frozen edge", dout, exp_mem[8'h70]);
      clk_en_n = 1'b0;
      drv(0, 0, 8'h72, SEL, 4'h0, '0);
      chk_bit("R4 write phase after release", dout_en, 1'b0);
      clk_en_n = 1'b1;
      drv(0, 1, 8'h00, SEL, 4'h0, 36'hF_0F0F_0F0F);
      drv(0, 1, 8'h00, SEL, 4'h0, 36'hF_0F0F_0F0F);
      chk_bit("R4 pending write held", dout_en, 1'b0);
      clk_en_n = 1'b0;
      drv(0, 1, 0, DESEL, 4'h0, 36'h9_8765_4321);   // R3: completes on deselect
      exp_mem[8'h72] = 36'h9_8765_4321;
      drv(0, 1, 8'h72, SEL, 4'hF, '0);
      chk_word("R3 write stored by deselect edge", dout, exp_mem[8'h72]);

      // R8: asynchronous output enable
      out_en_n = 1'b1; #1;
      chk_bit("R8 output enable high floats bus", dout_en, 1'b0);
      out_en_n = 1'b0; #1;
      chk_bit("R8 output enable restored", dout_en, 1'b1);
      drv(0, 1, 0, DESEL, 4'hF, '0);

      finish_up();
   end

endmodule